// File: doc/BRIEF.md
# Interrupt Collator Clock-Stop Handshake

This block sits beside an interrupt collator and negotiates with an external clock controller about stopping the collator clock. The controller pulls an active-low stop request. The block answers with either an active-low accept or a deny. It also drives a wake/active indication, which tells the controller whether the collator still needs its clock. Downstream messages count as finished only when the outstanding-message count is zero. Each raw interrupt line counts as settled only when it matches a stored snapshot.

The snapshot follows the line vector on every clock edge while the collator is running. It freezes once a stop has been accepted. While the clock is stopped, any line that moves away from its frozen value raises the active indication through a purely combinational path, so the clock controller can bring the clock back. Between the accept and the cycle after the accept is released, the block withholds permission to send messages downstream.

Top module: `irq_collator_clkstop`

## Requirements
- R1: After reset is released, with lines held steady and a zero pending count, stop_ack_n is 1, stop_deny is 0, send_en is 1 and wake_active is 0.
- R2: wake_active is 1 in any cycle where pend_cnt is non-zero.
- R3: wake_active is 1, without waiting for a clock edge, whenever line_i differs from the snapshot. In running states the snapshot reloads from line_i at every edge, so a line change keeps wake_active high until the next edge.
- R4: If wake_active is 1 at the decision edge (the second edge with stop_req_n low), stop_deny becomes 1 after that edge. It stays 1 while stop_req_n is low and falls after the first edge that sees stop_req_n high.
- R5: If wake_active is 0 at the decision edge, stop_ack_n becomes 0 after that edge.
- R6: send_en is 0 while stop_ack_n is 0 and for one further cycle after stop_ack_n returns to 1.
- R7: While stopped, a change on any line sets wake_active to 1 at once. stop_ack_n stays 0 until stop_req_n returns high.
- R8: stop_ack_n returns to 1 after the first edge that sees stop_req_n high. It never rises while stop_req_n is low.
- R9: If stop_req_n returns high before the decision edge, the block goes back to running without ever asserting accept or deny.
- R10: stop_ack_n = 0 and stop_deny = 1 never occur together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Collator clock |
| rst_n | input | 1 | Active-low reset; the snapshot loads from line_i while it is low |
| stop_req_n | input | 1 | Active-low clock-stop request from the clock controller |
| pend_cnt | input | CNT_W | Number of messages not yet passed downstream |
| line_i | input | N_LINES | Raw interrupt line vector |
| stop_ack_n | output | 1 | Active-low accept of the stop request |
| stop_deny | output | 1 | Stop request refused |
| wake_active | output | 1 | Clock still needed (pending messages or line change) |
| send_en | output | 1 | Permission to send messages downstream |

## Verification
The accept/deny decision and a new line change or pending count can land in the same cycle. In that case the decision must see the collision and deny, never accept. The bench provokes this directly by flipping a line in the very cycle the request is being judged. Constrained-random traffic then repeats the collision, and a bench-side reference of the handshake judges every cycle. The bench checks that wake_active rises within that same cycle and that stop_deny, not stop_ack_n, follows the edge.

// File: rtl/cgh_pkg.sv
package cgh_pkg;
  typedef enum logic [2:0] {
    ST_RUN  = 3'd0,
    ST_REQ  = 3'd1,
    ST_STOP = 3'd2,
    ST_EXIT = 3'd3,
    ST_DENY = 3'd4
  } cgh_state_e;

  // Stopped-side states in which downstream sends are withheld.
  function automatic logic f_sends_blocked(cgh_state_e s);
    return (s == ST_STOP) || (s == ST_EXIT);
  endfunction
endpackage

// File: rtl/cgh_line_watch.sv
module cgh_line_watch #(
  parameter int N_LINES = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               freeze,
  input  logic [N_LINES-1:0] line_i,
  output logic               changed_o
);
  logic [N_LINES-1:0] snap_q;
  logic [N_LINES-1:0] diff_w;

  function automatic logic [N_LINES-1:0] f_diff(logic [N_LINES-1:0] a, logic [N_LINES-1:0] b);
    return a ^ b;
  endfunction

  // Snapshot loads while in reset and while running; holds when frozen.
  always_ff @(posedge clk) begin
    if (!rst_n || !freeze) snap_q <= line_i;
  end

  assign diff_w    = f_diff(line_i, snap_q);
  assign changed_o = |diff_w;

  // R3: frozen snapshot with steady lines cannot change the mismatch flag
  p_frozen_steady_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (freeze && $past(freeze) && $stable(line_i)) |-> $stable(changed_o));
  // R3: running snapshot catches up after one edge of steady lines
  p_run_catchup_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(!freeze) && $stable(line_i)) |-> !changed_o);
endmodule

// File: rtl/cgh_busy_eval.sv
module cgh_busy_eval #(
  parameter int CNT_W = 8
) (
  input  logic [CNT_W-1:0] pend_cnt,
  input  logic             line_changed,
  output logic             pend_any,
  output logic             busy_o
);
  function automatic logic f_pending(logic [CNT_W-1:0] c);
    return c != '0;
  endfunction

  assign pend_any = f_pending(pend_cnt);
  assign busy_o   = pend_any | line_changed;
endmodule

// File: rtl/cgh_fsm.sv
module cgh_fsm
  import cgh_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_n,
  input  logic       busy,
  output cgh_state_e state_o,
  output logic       freeze_o,
  output logic       ack_n,
  output logic       deny,
  output logic       send_en
);
  cgh_state_e st_q, st_nxt;

  always_comb begin
    st_nxt = st_q;
    unique case (st_q)
      ST_RUN:  if (!req_n) st_nxt = ST_REQ;
      ST_REQ:  if (req_n) st_nxt = ST_RUN;
               else if (busy) st_nxt = ST_DENY;
               else st_nxt = ST_STOP;
      ST_STOP: if (req_n) st_nxt = ST_EXIT;
      ST_EXIT: st_nxt = ST_RUN;
      ST_DENY: if (req_n) st_nxt = ST_RUN;
      default: st_nxt = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_RUN;
      ack_n   <= 1'b1;
      deny    <= 1'b0;
      send_en <= 1'b1;
    end else begin
      st_q    <= st_nxt;
      ack_n   <= (st_nxt != ST_STOP);
      deny    <= (st_nxt == ST_DENY);
      send_en <= !f_sends_blocked(st_nxt);
    end
  end

  assign state_o  = st_q;
  assign freeze_o = (st_q == ST_STOP);

  // R10
  p_ack_deny_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(!ack_n && deny));
  // R4
  p_deny_on_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_REQ && !req_n && busy) |=> (deny && ack_n));
  // R5
  p_accept_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_REQ && !req_n && !busy) |=> !ack_n);
  // R6
  p_no_send_stopped_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !ack_n |-> !send_en);
  // R8
  p_ack_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ack_n) |-> $past(req_n));
endmodule

// File: rtl/irq_collator_clkstop.sv
module irq_collator_clkstop
  import cgh_pkg::*;
#(
  parameter int N_LINES = 32,
  parameter int CNT_W   = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               stop_req_n,
  input  logic [CNT_W-1:0]   pend_cnt,
  input  logic [N_LINES-1:0] line_i,
  output logic               stop_ack_n,
  output logic               stop_deny,
  output logic               wake_active,
  output logic               send_en
);
  logic       freeze_w;
  logic       line_changed_w;
  logic       pend_any_w;
  logic       busy_w;
  cgh_state_e state_w;

  cgh_line_watch #(.N_LINES(N_LINES)) u_watch (
    .clk       (clk),
    .rst_n     (rst_n),
    .freeze    (freeze_w),
    .line_i    (line_i),
    .changed_o (line_changed_w)
  );

  cgh_busy_eval #(.CNT_W(CNT_W)) u_busy (
    .pend_cnt     (pend_cnt),
    .line_changed (line_changed_w),
    .pend_any     (pend_any_w),
    .busy_o       (busy_w)
  );

  cgh_fsm u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_n    (stop_req_n),
    .busy     (busy_w),
    .state_o  (state_w),
    .freeze_o (freeze_w),
    .ack_n    (stop_ack_n),
    .deny     (stop_deny),
    .send_en  (send_en)
  );

  assign wake_active = busy_w;

  // R2
  p_busy_pending_r2: assert property (@(posedge clk) disable iff (!rst_n)
    pend_any_w |-> wake_active);
  // R7: accept held while stopped until request released
  p_hold_stop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_w == ST_STOP && !stop_req_n) |=> !stop_ack_n);
endmodule

// File: tb/tb_irq_collator_clkstop.sv
module tb_irq_collator_clkstop;
  localparam int NL = 32;
  localparam int CW = 8;
  localparam int M_RUN = 0, M_REQ = 1, M_STP = 2, M_EXIT = 3, M_DEN = 4;

  logic clk = 1'b0;
  logic rst_n;
  logic stop_req_n;
  logic [CW-1:0] pend_cnt;
  logic [NL-1:0] line_i;
  logic stop_ack_n, stop_deny, wake_active, send_en;

  int nchk = 0, nerr = 0;
  bit done = 0;
  int mst;
  logic [NL-1:0] msnap;

  always #5 clk = ~clk;

  irq_collator_clkstop #(.N_LINES(NL), .CNT_W(CW)) dut (
    .clk(clk), .rst_n(rst_n), .stop_req_n(stop_req_n), .pend_cnt(pend_cnt),
    .line_i(line_i), .stop_ack_n(stop_ack_n), .stop_deny(stop_deny),
    .wake_active(wake_active), .send_en(send_en)
  );

  function automatic bit f_busy(int c, logic [NL-1:0] l, logic [NL-1:0] s);
    return (c != 0) || (l != s);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(input bit r, input int c, input logic [NL-1:0] l);
    bit mb;
    @(negedge clk);
    chk("R5/R8 ack", 32'(stop_ack_n), 32'(mst != M_STP));
    chk("R4 deny",   32'(stop_deny),  32'(mst == M_DEN));
    chk("R6 send",   32'(send_en),    32'(!(mst == M_STP || mst == M_EXIT)));
    chk("R10 excl",  32'(!stop_ack_n && stop_deny), 32'd0);
    stop_req_n = r; pend_cnt = CW'(c); line_i = l;
    #1;
    if (c != 0) chk("R2 busy", 32'(wake_active), 32'd1);
    else        chk("R3 busy", 32'(wake_active), 32'(f_busy(c, l, msnap)));
    @(posedge clk);
    mb = f_busy(c, l, msnap);
    if (mst != M_STP) msnap = l;
    case (mst)
      M_RUN:  if (!r) mst = M_REQ;
      M_REQ:  mst = r ? M_RUN : (mb ? M_DEN : M_STP);
      M_STP:  if (r) mst = M_EXIT;
      M_EXIT: mst = M_RUN;
      M_DEN:  if (r) mst = M_RUN;
      default: mst = M_RUN;
    endcase
    #1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nerr++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", nchk, nerr);
      $finish;
    end
  end

  initial begin
    logic [NL-1:0] L;
    bit rq;
    void'($urandom(32'd2024));
    L = 32'hA5A5_0F0F;
    rst_n = 0; stop_req_n = 1; pend_cnt = 0; line_i = L;
    repeat (3) @(posedge clk);
    msnap = L; mst = M_RUN;
    @(negedge clk); rst_n = 1;
    #1;
    chk("R1 ack",  32'(stop_ack_n), 32'd1);
    chk("R1 deny", 32'(stop_deny), 32'd0);
    chk("R1 send", 32'(send_en), 32'd1);
    chk("R1 busy", 32'(wake_active), 32'd0);

    // R2: pending count alone holds wake_active
    step(1, 5, L);
    step(1, 0, L);
    // R5: idle request accepted after the decision edge
    step(0, 0, L); step(0, 0, L);
    chk("R5 accepted", 32'(stop_ack_n), 32'd0);
    chk("R6 blocked", 32'(send_en), 32'd0);
    // R7: line change while stopped wakes at once, accept holds
    step(0, 0, L ^ 32'h10);
    chk("R7 wake", 32'(wake_active), 32'd1);
    chk("R7 ack held", 32'(stop_ack_n), 32'd0);
    L = L ^ 32'h10;
    // R8: release
    step(1, 0, L);
    chk("R8 ack up", 32'(stop_ack_n), 32'd1);
    chk("R6 still blocked", 32'(send_en), 32'd0);
    step(1, 0, L);
    chk("R6 resumed", 32'(send_en), 32'd1);
    step(1, 0, L);
    chk("R3 caught up", 32'(wake_active), 32'd0);
    // R4: line flips in the decision cycle -> deny
    step(0, 0, L); step(0, 0, L ^ 32'h1);
    L = L ^ 32'h1;
    chk("R4 deny set", 32'(stop_deny), 32'd1);
    chk("R4 no ack", 32'(stop_ack_n), 32'd1);
    step(0, 0, L);
    chk("R4 deny held", 32'(stop_deny), 32'd1);
    step(1, 0, L);
    chk("R4 deny drop", 32'(stop_deny), 32'd0);
    // R9: withdrawn before decision
    step(0, 0, L); step(1, 0, L);
    chk("R9 no ack", 32'(stop_ack_n), 32'd1);
    chk("R9 no deny", 32'(stop_deny), 32'd0);
    // R4 via pending count in decision cycle
    step(0, 0, L); step(0, 3, L);
    chk("R4 deny pend", 32'(stop_deny), 32'd1);
    step(1, 0, L);

    // constrained random
    rq = 1;
    for (int i = 0; i < 3000; i++) begin
      int c;
      if (($urandom % 6) == 0) rq = !rq;
      c = (($urandom % 4) == 0) ? int'($urandom % 256) : 0;
      if (($urandom % 8) == 0) L[$urandom % NL] ^= 1'b1;
      step(rq, c, L);
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end
endmodule